// File: doc/BRIEF.md
# Three-Channel Interval Timer Host Register Interface

This block is the processor-facing register file of a three-channel interval timer. A host reaches it through an 8-bit data bus and a 2-bit address. Addresses 0 to 2 carry count bytes to and from one channel each. Address 3 takes control words. These control words set up a channel, freeze its count, or take a snapshot of count and status across several channels at once. The block holds no counting logic. It sends each channel its configuration and a 16-bit initial count with a one-cycle load strobe. Each channel sends back its live count, its output level and its null-count flag.

Each channel owns a small set of state machines. The write sequencer has states SEQ_LO and SEQ_HI. It moves SEQ_LO to SEQ_HI when the low byte of a word arrives, and SEQ_HI to SEQ_LO when the high byte arrives. A control word returns it to SEQ_LO. The read sequencer uses the same two states and the same transitions for unlatched word reads. The count-latch machine has the states CL_IDLE, CL_LO_ONLY, CL_HI_ONLY, CL_WORD_LO and CL_WORD_HI:
- An accepted latch moves it from CL_IDLE to the state that matches the access mode.
- A read moves it on: CL_WORD_LO goes to CL_WORD_HI, and every other state goes back to CL_IDLE.

A separate status-held flag is set by a status snapshot and cleared by the next read of that channel.

Top module: `itmr_host_if`

## Requirements
- R1: After reset every channel shows mode 0, binary counting and a count output of 0x0000, with no load or latch strobe. The stored access mode is LSB-then-MSB.
- R2: A write to address 3 whose bits 7:6 hold 0 to 2 and whose bits 5:4 are nonzero configures that channel. The access mode comes from bits 5:4 (1 = LSB only, 2 = MSB only, 3 = LSB then MSB). The mode comes from bits 3:1, with 6 read as 2 and 7 read as 3. The BCD flag comes from bit 0.
- R3: In LSB-only mode a data byte loads count {0x00, byte}. In MSB-only mode it loads {byte, 0x00}. In both cases the load strobe is high for the single cycle after the write.
- R4: In LSB-then-MSB mode the first byte is held without a load. The second byte loads {second, first}, and the sequence then expects the low byte again. Any new control word for the channel restarts the sequence at the low byte.
- R5: An unlatched read returns the live count by access mode: the low byte, the high byte, or low and high bytes on alternate reads in word mode.
- R6: A control word with bits 5:4 equal to 0 latches the selected channel's live count and pulses that channel's latch strobe for one cycle. Reads then return the frozen value by access mode, and the latch is released after the last byte.
- R7: A count latch or status latch request is ignored while an earlier latch of the same kind on that channel is still unread.
- R8: A control word with bits 7:6 equal to 3 is a read-back command. Bits 1, 2 and 3 pick channels 0, 1 and 2. Bit 5 at 0 latches their counts and bit 4 at 0 latches their status. Channels whose bit is 0 are untouched.
- R9: The status byte is {OUT, null_count, access[1:0], mode[2:0], BCD}, from bit 7 down to bit 0. A held status is returned before any held count and is released by that one read.
- R10: A read at address 3 returns 0x00 and changes no channel state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe; read data is consumed at the clock edge |
| addr | input | 2 | 0 to 2 select a channel, 3 selects control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address (combinational) |
| ch_mode | output | NCH*3 | Per-channel mode, channel g in bits [3g+2:3g] |
| ch_bcd | output | NCH | Per-channel BCD flag |
| ch_count | output | NCH*16 | Per-channel initial count |
| ch_load | output | NCH | One-cycle initial-count load strobe |
| ch_latch | output | NCH | One-cycle pulse when a count latch is accepted |
| ch_live | input | NCH*16 | Per-channel live count |
| ch_out | input | NCH | Per-channel OUT level |
| ch_null | input | NCH | Per-channel null-count flag |

## Verification
The assertions assume that the bus never raises `wr_en` and `rd_en` in the same cycle. They also assume that channel inputs seen at a latch edge are the ones meant for capture. The stimulus drives each strobe for exactly one cycle, with an idle cycle after it. It changes `ch_live`, `ch_out` and `ch_null` only between transactions, so every snapshot takes a known value. Read results are checked in the same cycle as the read strobe, before the clock edge that consumes the byte.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef enum logic {
        SEQ_LO = 1'b0,
        SEQ_HI = 1'b1
    } seq_e;

    typedef enum logic [2:0] {
        CL_IDLE    = 3'd0,
        CL_LO_ONLY = 3'd1,
        CL_HI_ONLY = 3'd2,
        CL_WORD_LO = 3'd3,
        CL_WORD_HI = 3'd4
    } clat_e;

    // Modes 6 and 7 alias modes 2 and 3.
    function automatic logic [2:0] fold_mode(input logic [2:0] m);
        return (m[2:1] == 2'b11) ? {1'b0, m[1:0]} : m;
    endfunction
endpackage

// File: rtl/itmr_ctl_dec.sv
module itmr_ctl_dec
    import itmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic              ctl_wr,
    input  logic [BYTE_W-1:0] ctl_byte,
    output logic [NCH-1:0]    cfg_wr,
    output logic [NCH-1:0]    cnt_lat,
    output logic [NCH-1:0]    st_lat,
    output logic [2:0]        cfg_mode,
    output acc_e              cfg_acc,
    output logic              cfg_bcd
);
    logic       is_rb;
    logic [1:0] sel;

    assign is_rb    = (ctl_byte[7:6] == 2'b11);
    assign sel      = ctl_byte[7:6];
    assign cfg_acc  = acc_e'(ctl_byte[5:4]);
    assign cfg_mode = fold_mode(ctl_byte[3:1]);
    assign cfg_bcd  = ctl_byte[0];

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        logic hit, rb_pick;
        assign hit       = !is_rb && (sel == 2'(g));
        assign rb_pick   = is_rb && ctl_byte[g + 1];
        assign cfg_wr[g] = ctl_wr && hit && (cfg_acc != ACC_LATCH);
        assign cnt_lat[g] = ctl_wr && ((hit && (cfg_acc == ACC_LATCH))
                                       || (rb_pick && !ctl_byte[5]));
        assign st_lat[g] = ctl_wr && rb_pick && !ctl_byte[4];
    end
endmodule

// File: rtl/itmr_chan.sv
module itmr_chan
    import itmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_mode,
    input  acc_e              cfg_acc,
    input  logic              cfg_bcd,
    input  logic              cnt_lat_req,
    input  logic              st_lat_req,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic              out_in,
    input  logic              null_in,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [2:0]        mode_o,
    output logic              bcd_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              load_o,
    output logic              latch_o
);
    acc_e              acc_q;
    seq_e              wr_st, wr_nx, rd_st, rd_nx;
    clat_e             cl_st, cl_nx;
    logic [BYTE_W-1:0] hold_lo;
    logic [CNT_W-1:0]  cnt_lat;
    logic [BYTE_W-1:0] st_lat;
    logic              st_valid;
    logic              rd_live;

    assign rd_live = data_rd && !st_valid && (cl_st == CL_IDLE);

    // Next-state logic for the three sequencers.
    always_comb begin
        wr_nx = wr_st;
        if (cfg_wr)                              wr_nx = SEQ_LO;
        else if (data_wr && acc_q == ACC_WORD)   wr_nx = (wr_st == SEQ_LO) ? SEQ_HI : SEQ_LO;

        rd_nx = rd_st;
        if (cfg_wr)                              rd_nx = SEQ_LO;
        else if (rd_live && acc_q == ACC_WORD)   rd_nx = (rd_st == SEQ_LO) ? SEQ_HI : SEQ_LO;

        cl_nx = cl_st;
        if (cnt_lat_req && cl_st == CL_IDLE) begin
            unique case (acc_q)
                ACC_LO:  cl_nx = CL_LO_ONLY;
                ACC_HI:  cl_nx = CL_HI_ONLY;
                default: cl_nx = CL_WORD_LO;
            endcase
        end else if (data_rd && !st_valid) begin
            unique case (cl_st)
                CL_WORD_LO: cl_nx = CL_WORD_HI;
                default:    cl_nx = CL_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_st <= SEQ_LO;
            rd_st <= SEQ_LO;
            cl_st <= CL_IDLE;
        end else begin
            wr_st <= wr_nx;
            rd_st <= rd_nx;
            cl_st <= cl_nx;
        end
    end

    // Configuration, latches and channel-facing outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= ACC_WORD;
            mode_o   <= 3'd0;
            bcd_o    <= 1'b0;
            hold_lo  <= '0;
            count_o  <= '0;
            load_o   <= 1'b0;
            latch_o  <= 1'b0;
            cnt_lat  <= '0;
            st_lat   <= '0;
            st_valid <= 1'b0;
        end else begin
            load_o  <= 1'b0;
            latch_o <= 1'b0;
            if (cfg_wr) begin
                acc_q  <= cfg_acc;
                mode_o <= cfg_mode;
                bcd_o  <= cfg_bcd;
            end
            if (data_wr) begin
                unique case (acc_q)
                    ACC_LO: begin
                        count_o <= {{BYTE_W{1'b0}}, wdata};
                        load_o  <= 1'b1;
                    end
                    ACC_HI: begin
                        count_o <= {wdata, {BYTE_W{1'b0}}};
                        load_o  <= 1'b1;
                    end
                    default: begin
                        if (wr_st == SEQ_LO) begin
                            hold_lo <= wdata;
                        end else begin
                            count_o <= {wdata, hold_lo};
                            load_o  <= 1'b1;
                        end
                    end
                endcase
            end
            if (cnt_lat_req && cl_st == CL_IDLE) begin
                cnt_lat <= live_cnt;
                latch_o <= 1'b1;
            end
            if (st_lat_req && !st_valid) begin
                st_lat   <= {out_in, null_in, acc_q, mode_o, bcd_o};
                st_valid <= 1'b1;
            end else if (data_rd && st_valid) begin
                st_valid <= 1'b0;
            end
        end
    end

    // Read data: status first, then a held count, then the live count.
    always_comb begin
        if (st_valid) begin
            rd_byte = st_lat;
        end else begin
            unique case (cl_st)
                CL_LO_ONLY, CL_WORD_LO: rd_byte = cnt_lat[BYTE_W-1:0];
                CL_HI_ONLY, CL_WORD_HI: rd_byte = cnt_lat[CNT_W-1:BYTE_W];
                default: begin
                    if (acc_q == ACC_HI || (acc_q == ACC_WORD && rd_st == SEQ_HI))
                        rd_byte = live_cnt[CNT_W-1:BYTE_W];
                    else
                        rd_byte = live_cnt[BYTE_W-1:0];
                end
            endcase
        end
    end

    // R3
    load_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> $past(data_wr));
    // R4
    word_first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && acc_q == ACC_WORD && wr_st == SEQ_LO) |=> !load_o);
    // R7
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_lat_req) |=> $stable(st_lat));
    // R7
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_st != CL_IDLE && cnt_lat_req) |=> ($stable(cnt_lat) && !latch_o));
    // R2
    mode_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o[2:1] != 2'b11);
endmodule

// File: rtl/itmr_host_if.sv
module itmr_host_if
    import itmr_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [1:0]           addr,
    input  logic [BYTE_W-1:0]    wdata,
    output logic [BYTE_W-1:0]    rdata,
    output logic [NCH*3-1:0]     ch_mode,
    output logic [NCH-1:0]       ch_bcd,
    output logic [NCH*CNT_W-1:0] ch_count,
    output logic [NCH-1:0]       ch_load,
    output logic [NCH-1:0]       ch_latch,
    input  logic [NCH*CNT_W-1:0] ch_live,
    input  logic [NCH-1:0]       ch_out,
    input  logic [NCH-1:0]       ch_null
);
    localparam logic [1:0] CTL_ADDR = 2'd3;

    logic              ctl_wr;
    logic [NCH-1:0]    cfg_wr, cnt_lat, st_lat;
    logic [2:0]        cfg_mode;
    acc_e              cfg_acc;
    logic              cfg_bcd;
    logic [BYTE_W-1:0] rd_bytes [NCH];

    assign ctl_wr = wr_en && (addr == CTL_ADDR);

    itmr_ctl_dec #(.NCH(NCH)) u_dec (
        .ctl_wr   (ctl_wr),
        .ctl_byte (wdata),
        .cfg_wr   (cfg_wr),
        .cnt_lat  (cnt_lat),
        .st_lat   (st_lat),
        .cfg_mode (cfg_mode),
        .cfg_acc  (cfg_acc),
        .cfg_bcd  (cfg_bcd)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        itmr_chan u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg_wr      (cfg_wr[g]),
            .cfg_mode    (cfg_mode),
            .cfg_acc     (cfg_acc),
            .cfg_bcd     (cfg_bcd),
            .cnt_lat_req (cnt_lat[g]),
            .st_lat_req  (st_lat[g]),
            .data_wr     (wr_en && addr == 2'(g)),
            .data_rd     (rd_en && addr == 2'(g)),
            .wdata       (wdata),
            .live_cnt    (ch_live[g*CNT_W +: CNT_W]),
            .out_in      (ch_out[g]),
            .null_in     (ch_null[g]),
            .rd_byte     (rd_bytes[g]),
            .mode_o      (ch_mode[g*3 +: 3]),
            .bcd_o       (ch_bcd[g]),
            .count_o     (ch_count[g*CNT_W +: CNT_W]),
            .load_o      (ch_load[g]),
            .latch_o     (ch_latch[g])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++)
            if (addr == 2'(i)) rdata = rd_bytes[i];
    end

    // R10
    ctl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == CTL_ADDR) |-> (rdata == '0));
    // R6
    latch_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_latch != '0) |-> $past(ctl_wr));
endmodule

// File: tb/itmr_host_if_tb.sv
`timescale 1ns/100ps
module itmr_host_if_tb;
    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rdata;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd, ch_load, ch_latch;
    logic [47:0] ch_count;
    logic [47:0] ch_live = '0;
    logic [2:0]  ch_out = '0, ch_null = '0;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_q[$];
    string      req_q[$];

    always #2.5 clk = ~clk;

    itmr_host_if #(.NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ch_mode(ch_mode), .ch_bcd(ch_bcd),
        .ch_count(ch_count), .ch_load(ch_load), .ch_latch(ch_latch),
        .ch_live(ch_live), .ch_out(ch_out), .ch_null(ch_null)
    );

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Driver: push the expected byte, then issue the read.
    task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(posedge clk); #1;
        exp_q.push_back(exp); req_q.push_back(req);
        rd_en = 1'b1; addr = a;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    // Monitor: compare read data mid-cycle, before the consuming edge.
    always @(negedge clk) begin
        if (rd_en) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL scoreboard underflow actual=0x%0h expected=none", rdata);
            end else begin
                check(req_q.pop_front(), {40'd0, rdata}, {40'd0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        check("R1 mode", ch_mode, 0);
        check("R1 bcd", ch_bcd, 0);
        check("R1 count", ch_count, 0);
        check("R1 strobes", {ch_load, ch_latch}, 0);

        // R2/R4: ch0 word mode, mode 2
        bus_wr(2'd3, 8'h34);
        check("R2 ch0 mode", ch_mode[2:0], 2);
        bus_wr(2'd0, 8'h12);
        check("R4 no load on first byte", ch_load, 0);
        bus_wr(2'd0, 8'h56);
        check("R4 load strobe", ch_load, 3'b001);
        check("R4 word count", ch_count[15:0], 16'h5612);

        // R2/R3: ch1 LSB only, mode 7 folds to 3
        bus_wr(2'd3, 8'h5E);
        check("R2 fold 7->3", ch_mode[5:3], 3);
        bus_wr(2'd1, 8'hAB);
        check("R3 lsb load", {ch_load, ch_count[31:16]}, {3'b010, 16'h00AB});
        // ch2 MSB only, BCD
        bus_wr(2'd3, 8'hA1);
        check("R2 ch2 bcd", ch_bcd, 3'b100);
        bus_wr(2'd2, 8'h7C);
        check("R3 msb load", {ch_load, ch_count[47:32]}, {3'b100, 16'h7C00});

        // R5 unlatched reads
        ch_live = {16'h4411, 16'h9988, 16'h1234};
        bus_rd(2'd0, 8'h34, "R5 word lo");
        bus_rd(2'd0, 8'h12, "R5 word hi");
        bus_rd(2'd1, 8'h88, "R5 lsb only");
        bus_rd(2'd1, 8'h88, "R5 lsb only again");
        bus_rd(2'd2, 8'h44, "R5 msb only");

        // R6/R7 counter latch
        bus_wr(2'd3, 8'h00);
        check("R6 latch strobe", ch_latch, 3'b001);
        ch_live[15:0] = 16'hBEEF;
        bus_wr(2'd3, 8'h00);
        check("R7 second latch ignored", ch_latch, 3'b000);
        bus_rd(2'd0, 8'h34, "R6 latched lo");
        bus_rd(2'd0, 8'h12, "R6 latched hi");
        bus_rd(2'd0, 8'hEF, "R6 released lo");
        bus_rd(2'd0, 8'hBE, "R6 released hi");

        // R4 control word restarts the byte sequence
        bus_wr(2'd0, 8'h11);
        bus_wr(2'd3, 8'h34);
        bus_wr(2'd0, 8'h22);
        check("R4 restart no load", ch_load, 0);
        bus_wr(2'd0, 8'h33);
        check("R4 restart count", ch_count[15:0], 16'h3322);

        // R8/R9 read-back on ch1 and ch2, count and status
        ch_out = 3'b010; ch_null = 3'b100;
        bus_wr(2'd3, 8'hCC);
        check("R8 latch select", ch_latch, 3'b110);
        ch_live[31:16] = 16'h7766;
        ch_live[47:32] = 16'h5500;
        bus_rd(2'd1, 8'h96, "R9 ch1 status");
        bus_rd(2'd1, 8'h88, "R8 ch1 latched count");
        bus_rd(2'd1, 8'h66, "R8 ch1 live");
        bus_rd(2'd2, 8'h61, "R9 ch2 status");
        bus_rd(2'd2, 8'h44, "R8 ch2 latched count");
        bus_rd(2'd2, 8'h55, "R8 ch2 live");

        // R7/R9 status only on ch0, second request ignored
        ch_out = 3'b000;
        bus_wr(2'd3, 8'hE2);
        check("R8 status only no count latch", ch_latch, 0);
        ch_out = 3'b001;
        bus_wr(2'd3, 8'hE2);
        bus_rd(2'd0, 8'h34, "R7 first status kept");
        bus_rd(2'd0, 8'hEF, "R9 status released lo");
        bus_rd(2'd0, 8'hBE, "R9 status released hi");

        // R10 address 3 read
        bus_wr(2'd3, 8'hE2);
        bus_rd(2'd3, 8'h00, "R10 ctl read zero");
        bus_rd(2'd0, 8'hB4, "R10 status untouched");
        bus_rd(2'd0, 8'hEF, "R10 sequence untouched");

        // R2 mode 6 folds to 2, R3 lsb on ch0
        bus_wr(2'd3, 8'h1C);
        check("R2 fold 6->2", {ch_mode[2:0], ch_bcd[0]}, {3'd2, 1'b0});
        bus_wr(2'd0, 8'h99);
        check("R3 ch0 lsb load", ch_count[15:0], 16'h0099);

        repeat (2) @(posedge clk);
        check("scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule